// File: doc/BRIEF.md
# Snapshot Scan-Set Register

This block places a serial shadow chain beside a bank of system flip-flops. The system bank holds functional state: each cycle it either captures the functional logic, takes a preset from the shadow chain, or holds. The shadow chain is a test and debug path next to it. It can shift serially between a scan input and a scan output. It can also take a parallel snapshot of the system bank without disturbing the bank.

Debug software uses it in two ways. To read the state, it strobes a snapshot and then shifts the captured word out while the functional path keeps running. To preset the state, it shifts a word in and then strobes a transfer into the system bank. Four strobes select the operations, and all of them act on the rising edge of the single clock. Two internal decoders turn the strobes into one shadow operation per cycle (SH_HOLD, SH_SHIFT, SH_SNAP) and one system operation per cycle (SYS_HOLD, SYS_RUN, SYS_LOAD). No other states exist and there are no multi-cycle transitions: the decoded operation for each cycle comes purely from the strobes in that cycle.

Top module: `snapshot_scan_reg`

## Requirements
- R1: While `rst_n` is low, both the system bank and the shadow chain are cleared to 0, so `sys_q` and `scan_out` read 0 after reset.
- R2: With `shift_en` high (and `snap_en` low), the shadow chain moves one place toward its most significant cell on each edge. `scan_in` enters cell 0, and `scan_out` shows the most significant cell, so a bit applied at `scan_in` appears at `scan_out` after WIDTH shift edges.
- R3: With `xfer_en` high, every shadow cell is copied in parallel into the system bank on that edge.
- R4: With `snap_en` high, the shadow chain loads the current value of `sys_q` in parallel on that edge. A snapshot alone never changes `sys_q`.
- R5: With `run_en` high and `xfer_en` low, the system bank captures `func_d` on that edge.
- R6: When `xfer_en` and `run_en` are both high, the system bank takes the shadow contents and `func_d` is ignored.
- R7: When `snap_en` and `shift_en` are both high, the shadow chain takes the snapshot and does not shift.
- R8: Shifting the shadow chain in the same cycle as a functional capture leaves `sys_q` equal to `func_d`, with no shadow data reaching the system bank.
- R9: With no strobe high, `sys_q` and the shadow chain hold their values whatever `func_d` and `scan_in` do.
- R10: A snapshot in the same cycle as a functional capture records the system value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for both banks |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_in | input | 1 | Serial input to shadow cell 0 |
| scan_out | output | 1 | Most significant shadow cell |
| shift_en | input | 1 | Shift the shadow chain one place |
| xfer_en | input | 1 | Copy shadow cells into the system bank |
| snap_en | input | 1 | Copy the system bank into the shadow cells |
| run_en | input | 1 | Capture functional logic into the system bank |
| func_d | input | WIDTH | Functional logic outputs |
| sys_q | output | WIDTH | System bank contents |

## Verification
A corrupted system cell shows up on `sys_q` one edge after the operation that wrote it. A corrupted shadow cell stays hidden until it reaches the most significant position. That takes as many as WIDTH shift edges, or one transfer edge, which moves it onto `sys_q` at once. The bench therefore follows each snapshot or shift sequence with either a serial readout or a transfer. The vector table covers every pairing of strobes in which one operation has priority over another, including a transfer and a snapshot in the same cycle, which swaps the two banks.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        SH_HOLD  = 2'd0,
        SH_SHIFT = 2'd1,
        SH_SNAP  = 2'd2
    } sh_op_e;

    typedef enum logic [1:0] {
        SYS_HOLD = 2'd0,
        SYS_RUN  = 2'd1,
        SYS_LOAD = 2'd2
    } sys_op_e;

endpackage

// File: rtl/ssr_op_decode.sv
module ssr_op_decode
    import ssr_pkg::*;
(
    input  logic    shift_en,
    input  logic    xfer_en,
    input  logic    snap_en,
    input  logic    run_en,
    output sh_op_e  sh_op,
    output sys_op_e sys_op
);

    // Shadow side: the snapshot wins over a shift.
    always_comb begin
        if (snap_en)
            sh_op = SH_SNAP;
        else if (shift_en)
            sh_op = SH_SHIFT;
        else
            sh_op = SH_HOLD;
    end

    // System side: the preset from the shadow wins over functional capture.
    always_comb begin
        if (xfer_en)
            sys_op = SYS_LOAD;
        else if (run_en)
            sys_op = SYS_RUN;
        else
            sys_op = SYS_HOLD;
    end

endmodule

// File: rtl/ssr_shadow_chain.sv
module ssr_shadow_chain
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sh_op_e           op,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] cells_q
);

    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] cells_d;

    assign shifted[0] = ser_in;
    for (genvar g = 1; g < WIDTH; g++) begin : g_link
        assign shifted[g] = cells_q[g-1];
    end

    always_comb begin
        unique case (op)
            SH_SHIFT: cells_d = shifted;
            SH_SNAP:  cells_d = par_in;
            default:  cells_d = cells_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cells_q <= '0;
        else
            cells_q <= cells_d;
    end

endmodule

// File: rtl/ssr_system_bank.sv
module ssr_system_bank
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sys_op_e          op,
    input  logic [WIDTH-1:0] func_d,
    input  logic [WIDTH-1:0] preset_d,
    output logic [WIDTH-1:0] state_q
);

    logic [WIDTH-1:0] state_d;

    always_comb begin
        unique case (op)
            SYS_RUN:  state_d = func_d;
            SYS_LOAD: state_d = preset_d;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

endmodule

// File: rtl/snapshot_scan_reg.sv
module snapshot_scan_reg
    import ssr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scan_in,
    output logic             scan_out,
    input  logic             shift_en,
    input  logic             xfer_en,
    input  logic             snap_en,
    input  logic             run_en,
    input  logic [WIDTH-1:0] func_d,
    output logic [WIDTH-1:0] sys_q
);

    localparam int MSB = WIDTH - 1;

    sh_op_e           sh_op;
    sys_op_e          sys_op;
    logic [WIDTH-1:0] shadow_q;

    ssr_op_decode i_decode (
        .shift_en (shift_en),
        .xfer_en  (xfer_en),
        .snap_en  (snap_en),
        .run_en   (run_en),
        .sh_op    (sh_op),
        .sys_op   (sys_op)
    );

    ssr_shadow_chain #(.WIDTH(WIDTH)) i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (sh_op),
        .ser_in  (scan_in),
        .par_in  (sys_q),
        .cells_q (shadow_q)
    );

    ssr_system_bank #(.WIDTH(WIDTH)) i_system (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (sys_op),
        .func_d   (func_d),
        .preset_d (shadow_q),
        .state_q  (sys_q)
    );

    assign scan_out = shadow_q[MSB];

endmodule

// File: rtl/snapshot_scan_reg_chk.sv
module snapshot_scan_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scan_in,
    input logic             scan_out,
    input logic             shift_en,
    input logic             xfer_en,
    input logic             snap_en,
    input logic             run_en,
    input logic [WIDTH-1:0] func_d,
    input logic [WIDTH-1:0] sys_q,
    input logic [WIDTH-1:0] shadow
);

    // R3 and R6: a transfer always presets the system bank
    a_r3_xfer_presets: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> sys_q == $past(shadow));

    // R5 and R8: functional capture when no transfer is pending
    a_r5_run_captures: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !xfer_en) |=> sys_q == $past(func_d));

    // R4 and R10: a snapshot records the system value from before the edge
    a_r4_snap_loads: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> shadow == $past(sys_q));

    // R4: a snapshot on its own leaves the system bank alone
    a_r4_snap_no_disturb: assert property (@(posedge clk) disable iff (!rst_n)
        (snap_en && !run_en && !xfer_en) |=> $stable(sys_q));

    // R2 and R7: a shift without a snapshot moves the chain one place
    a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !snap_en) |=>
            shadow == {$past(shadow[WIDTH-2:0]), $past(scan_in)});

    // R9: with no strobe, both banks hold
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !xfer_en && !snap_en && !run_en) |=>
            ($stable(sys_q) && $stable(shadow)));

    // R2: the serial output follows the top shadow cell
    a_r2_scan_out_top: assert property (@(posedge clk) disable iff (!rst_n)
        scan_out == shadow[WIDTH-1]);

endmodule

bind snapshot_scan_reg snapshot_scan_reg_chk #(.WIDTH(WIDTH)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_in  (scan_in),
    .scan_out (scan_out),
    .shift_en (shift_en),
    .xfer_en  (xfer_en),
    .snap_en  (snap_en),
    .run_en   (run_en),
    .func_d   (func_d),
    .sys_q    (sys_q),
    .shadow   (shadow_q)
);

// File: tb/test_snapshot_scan_reg.sv
module test_snapshot_scan_reg;

    localparam int W = 8;

    typedef struct packed {
        logic         shift;
        logic         xfer;
        logic         snap;
        logic         run;
        logic         sin;
        logic [W-1:0] fd;
        logic [W-1:0] exp_sys;
        logic         exp_so;
    } vec_t;

    localparam int NV = 14;
    // Shadow shifts toward the MSB; scan_out is the MSB.
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'hA5,8'hA5,1'b0}, // R5 capture
        '{1'b0,1'b0,1'b0,1'b1,1'b0,8'h3C,8'h3C,1'b0}, // R5 capture
        '{1'b0,1'b0,1'b1,1'b0,1'b0,8'hFF,8'h3C,1'b0}, // R4 snapshot, sh=3C
        '{1'b0,1'b0,1'b0,1'b0,1'b1,8'h11,8'h3C,1'b0}, // R9 idle
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h22,8'h3C,1'b0}, // R2 sh=79
        '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h33,8'h3C,1'b1}, // R2 sh=F2
        '{1'b1,1'b0,1'b0,1'b0,1'b1,8'h44,8'h3C,1'b1}, // R2 sh=E5
        '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h55,8'hE5,1'b1}, // R3 transfer
        '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h0F,8'hE5,1'b1}, // R6 transfer wins
        '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h66,8'hE5,1'b1}, // R7 snapshot wins, sh=E5
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h5A,8'h5A,1'b1}, // R8 shift+run, sh=CA
        '{1'b0,1'b0,1'b1,1'b1,1'b0,8'hC3,8'hC3,1'b0}, // R10 sh=5A
        '{1'b1,1'b0,1'b0,1'b1,1'b0,8'hC3,8'hC3,1'b1}, // R2 sh=B4
        '{1'b0,1'b1,1'b1,1'b0,1'b0,8'h00,8'hB4,1'b1}  // R3/R4 swap, sh=C3
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out;
    logic         shift_en = 1'b0;
    logic         xfer_en = 1'b0;
    logic         snap_en = 1'b0;
    logic         run_en = 1'b0;
    logic [W-1:0] func_d = '0;
    logic [W-1:0] sys_q;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    snapshot_scan_reg #(.WIDTH(W)) i_snapshot_scan_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .scan_in  (scan_in),
        .scan_out (scan_out),
        .shift_en (shift_en),
        .xfer_en  (xfer_en),
        .snap_en  (snap_en),
        .run_en   (run_en),
        .func_d   (func_d),
        .sys_q    (sys_q)
    );

    task automatic check_sys(input string req, input logic [W-1:0] exp);
        checks++;
        if (sys_q !== exp) begin
            fails++;
            $display("FAIL %s sys_q actual=%h expected=%h", req, sys_q, exp);
        end
    endtask

    task automatic check_so(input string req, input logic exp);
        checks++;
        if (scan_out !== exp) begin
            fails++;
            $display("FAIL %s scan_out actual=%b expected=%b", req, scan_out, exp);
        end
    endtask

    task automatic drive(input logic sh, input logic xf, input logic sn,
                         input logic rn, input logic si, input logic [W-1:0] fd);
        shift_en = sh; xfer_en = xf; snap_en = sn; run_en = rn;
        scan_in = si; func_d = fd;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check_sys("R1", '0);
        check_so("R1", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].shift, TBL[i].xfer, TBL[i].snap, TBL[i].run,
                  TBL[i].sin, TBL[i].fd);
            check_sys($sformatf("R%0s vec%0d", "x", i), TBL[i].exp_sys);
            check_so($sformatf("vec%0d", i), TBL[i].exp_so);
        end

        // R9: idle with changing inputs, shadow read back by transfer later
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h99);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h66);
        check_sys("R9", 8'hB4);
        check_so("R9", 1'b1);
        drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
        check_sys("R9 shadow held", 8'hC3);

        // R1: reset in the middle of activity clears both banks
        shift_en = 1'b1; run_en = 1'b1; func_d = 8'hFF; scan_in = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check_sys("R1 mid-run", '0);
        check_so("R1 mid-run", 1'b0);
        rst_n = 1'b1;
        shift_en = 1'b0; run_en = 1'b0;
        @(negedge clk);

        // R2: a one at scan_in reaches scan_out after exactly W shifts
        for (int k = 1; k <= W; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
            check_so($sformatf("R2 latency k=%0d", k), (k == W));
        end
        check_sys("R2 shift leaves system", '0);

        // R4: snapshot of zeros leaves sys_q alone and clears the chain
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'hAA);
        check_sys("R4 no disturb", '0);
        check_so("R4 snapshot", 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule